// File: doc/BRIEF.md
# SAR Conversion Sequencer with Select Filter

This block is the conversion-clock side of a 10-bit successive-approximation converter. The serial front end hands over control by flipping a toggle line. The toggle crosses into the free-running conversion clock through a synchronizer. The sequencer then runs a frame of fixed length. In that frame it presents trial codes to an external DAC and reads back one comparator bit for each trial. The bits are decided most significant first. At the end of the frame the code is captured into a result register, and the end-of-conversion flag rises to show the result is ready.

The raw active-low chip select is synchronized and then debounced before the block acts on it. A change is taken only after the new level has survived the synchronizer and two further clock edges. Any accepted change of the select during a conversion cuts the frame short. The previous result is kept in that case.

Three channel codes are reserved for self-test. When the test option is built in, they replace the external comparator with an internal ideal comparison against a fixed level: mid-scale, zero or full-scale.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is high and right after it, `eoc` is 1, `result` is 0x000, `dac_code` is 0x000 and `sel_n` is 1.
- R2: A change of level on `start_tgl` while idle starts a conversion. `eoc` goes low on the third rising `clk` edge after the change.
- R3: An uninterrupted conversion keeps `eoc` low for exactly 44 clock cycles. `eoc` rises on the 47th rising edge after the toggle.
- R4: `dac_code` is 0 while idle and during the two setup cycles. Each bit is then tried for 4 cycles, most significant first. The first trial is 0x200. The second trial is 0x300 if the first decision was 1, and 0x100 if it was 0.
- R5: The result bit for each trial is the value of `cmp_in` (1 = keep the bit) on the last cycle of that bit's slot. With an ideal comparator (`cmp_in` = 1 when `dac_code` <= input), `result` equals the input code. `result` changes only on the edge where a completed conversion raises `eoc`.
- R6: A `start_tgl` change that arrives while a conversion runs is dropped. It starts no second conversion.
- R7: `sel_n` takes a new `cs_n` level on the fourth rising edge after `cs_n` changes, provided the level is held. A `cs_n` pulse lasting one cycle leaves `sel_n` unchanged.
- R8: An accepted change of `sel_n` in either direction during a conversion ends the conversion on that same edge. `eoc` returns to 1 and `result` keeps its previous value.
- R9: With the test option on, channels 0xB, 0xC and 0xD give 0x200, 0x000 and 0x3FF whatever `cmp_in` does. Other channel values use `cmp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_tgl | input | 1 | Handoff toggle from the serial domain, asynchronous |
| cs_n | input | 1 | Raw active-low chip select, asynchronous |
| chan | input | 4 | Channel code, captured when a conversion starts |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Last completed conversion result |
| eoc | output | 1 | End of conversion: low while converting, high when idle |
| sel_n | output | 1 | Filtered chip-select level |

## Verification
The hardest case to reach is the abort. The select must be accepted in the middle of a frame, after the synchronizer and filter delays, and the monitor must then tell the early rise of `eoc` apart from a normal completion. The stimulus starts a conversion, lets it run 20 cycles, and then moves `cs_n`. At that point the scoreboard holds no expected item and carries an abort mark. When `eoc` rises, the bench checks that the old result survived. It then checks that no late completion follows. A one-cycle select glitch and a second toggle during a busy frame are also driven. Each is checked at the ports for having no effect.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    // Sequencer phases within one conversion frame
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_TRIAL = 2'd2,
        PH_LATCH = 2'd3
    } phase_e;

    // Reserved self-test channel codes
    localparam logic [3:0] CH_TEST_MID  = 4'hB;
    localparam logic [3:0] CH_TEST_LOW  = 4'hC;
    localparam logic [3:0] CH_TEST_HIGH = 4'hD;

    typedef enum logic [1:0] {
        TL_NONE = 2'd0,
        TL_MID  = 2'd1,
        TL_LOW  = 2'd2,
        TL_HIGH = 2'd3
    } test_lvl_e;

    function automatic test_lvl_e decode_test(input logic [3:0] ch);
        case (ch)
            CH_TEST_MID:  return TL_MID;
            CH_TEST_LOW:  return TL_LOW;
            CH_TEST_HIGH: return TL_HIGH;
            default:      return TL_NONE;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_toggle_sync.sv
module sar_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], tgl_in};
            last_q <= chain[STAGES-1];
        end
    end

    assign pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/sar_sel_filter.sv
module sar_sel_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_EDGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic level_n,
    output logic change
);
    localparam int unsigned CNT_W = (HOLD_EDGES < 2) ? 1 : $clog2(HOLD_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_EDGES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       hold_cnt;
    logic                   differs;

    assign differs = sync_q[SYNC_STAGES-1] != level_n;
    assign change  = differs && (hold_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            level_n  <= 1'b1;
            hold_cnt <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
            if (change) begin
                level_n  <= sync_q[SYNC_STAGES-1];
                hold_cnt <= '0;
            end else if (differs) begin
                hold_cnt <= hold_cnt + 1'b1;
            end else begin
                hold_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_conv_pkg::*;
#(
    parameter int unsigned W          = 10,
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned CYC_PER_BIT = 4,
    parameter int unsigned LATCH_CYC  = 2,
    parameter bit          TEST_EN    = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic [3:0]   chan,
    input  logic         cmp_in,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic         eoc
);
    localparam int unsigned SUB_MAX = max3(SETUP_CYC, CYC_PER_BIT, LATCH_CYC);
    localparam int unsigned SUB_W   = (SUB_MAX < 2) ? 1 : $clog2(SUB_MAX);
    localparam int unsigned BIT_W   = (W < 2) ? 1 : $clog2(W);
    localparam logic [SUB_W-1:0] SETUP_LAST = SUB_W'(SETUP_CYC - 1);
    localparam logic [SUB_W-1:0] BIT_LAST   = SUB_W'(CYC_PER_BIT - 1);
    localparam logic [SUB_W-1:0] LATCH_LAST = SUB_W'(LATCH_CYC - 1);
    localparam logic [BIT_W-1:0] MSB_IDX    = BIT_W'(W - 1);

    phase_e           phase;
    logic [SUB_W-1:0] sub_cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [W-1:0]     approx;
    logic [W-1:0]     trial;
    logic [3:0]       chan_q;
    logic             cmp_eff;

    assign trial = approx | (W'(1) << bit_idx);

    always_comb begin
        case (phase)
            PH_TRIAL: dac_code = trial;
            PH_LATCH: dac_code = approx;
            default:  dac_code = '0;
        endcase
    end

    generate
        if (TEST_EN) begin : g_test
            test_lvl_e    lvl;
            logic [W-1:0] ref_code;
            assign lvl = decode_test(chan_q);
            always_comb begin
                case (lvl)
                    TL_MID:  ref_code = {1'b1, {(W-1){1'b0}}};
                    TL_HIGH: ref_code = '1;
                    default: ref_code = '0;
                endcase
            end
            assign cmp_eff = (lvl == TL_NONE) ? cmp_in : (trial <= ref_code);
        end else begin : g_notest
            assign cmp_eff = cmp_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            sub_cnt <= '0;
            bit_idx <= MSB_IDX;
            approx  <= '0;
            result  <= '0;
            eoc     <= 1'b1;
            chan_q  <= '0;
        end else if (phase != PH_IDLE && abort) begin
            phase   <= PH_IDLE;
            sub_cnt <= '0;
            approx  <= '0;
            eoc     <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_SETUP;
                        sub_cnt <= '0;
                        bit_idx <= MSB_IDX;
                        approx  <= '0;
                        chan_q  <= chan;
                        eoc     <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (sub_cnt == SETUP_LAST) begin
                        phase   <= PH_TRIAL;
                        sub_cnt <= '0;
                    end else begin
                        sub_cnt <= sub_cnt + 1'b1;
                    end
                end
                PH_TRIAL: begin
                    if (sub_cnt == BIT_LAST) begin
                        approx[bit_idx] <= cmp_eff;
                        sub_cnt         <= '0;
                        if (bit_idx == '0) begin
                            phase <= PH_LATCH;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end else begin
                        sub_cnt <= sub_cnt + 1'b1;
                    end
                end
                PH_LATCH: begin
                    if (sub_cnt == LATCH_LAST) begin
                        result  <= approx;
                        eoc     <= 1'b1;
                        phase   <= PH_IDLE;
                        sub_cnt <= '0;
                    end else begin
                        sub_cnt <= sub_cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int unsigned RES_W       = 10,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned CYC_PER_BIT = 4,
    parameter int unsigned LATCH_CYC   = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_EDGES  = 2,
    parameter bit          TEST_EN     = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_tgl,
    input  logic             cs_n,
    input  logic [3:0]       chan,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             eoc,
    output logic             sel_n
);
    localparam int unsigned FRAME_CYC = SETUP_CYC + RES_W * CYC_PER_BIT + LATCH_CYC;

    logic start_pulse;
    logic sel_change;

    sar_toggle_sync #(.STAGES(SYNC_STAGES)) u_handoff (
        .clk   (clk),
        .rst   (rst),
        .tgl_in(start_tgl),
        .pulse (start_pulse)
    );

    sar_sel_filter #(.SYNC_STAGES(SYNC_STAGES), .HOLD_EDGES(HOLD_EDGES)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .raw_n  (cs_n),
        .level_n(sel_n),
        .change (sel_change)
    );

    sar_seq #(
        .W          (RES_W),
        .SETUP_CYC  (SETUP_CYC),
        .CYC_PER_BIT(CYC_PER_BIT),
        .LATCH_CYC  (LATCH_CYC),
        .TEST_EN    (TEST_EN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_pulse),
        .abort   (sel_change),
        .chan    (chan),
        .cmp_in  (cmp_in),
        .dac_code(dac_code),
        .result  (result),
        .eoc     (eoc)
    );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int unsigned RES_W = 10,
    parameter int unsigned FRAME = 44
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic [RES_W-1:0] dac_code,
    input logic [RES_W-1:0] result,
    input logic             eoc,
    input logic             sel_n
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) low_cnt <= '0;
        else if (eoc) low_cnt <= '0;
        else low_cnt <= low_cnt + 1'b1;
    end

    // R3: a completion that is not an abort follows exactly FRAME low cycles
    a_r3_frame_length: assert property (@(posedge clk) disable iff (rst)
        ($rose(eoc) && $stable(sel_n)) |-> (low_cnt == 16'(FRAME)));

    // R4: no trial code is driven while idle
    a_r4_dac_idle_zero: assert property (@(posedge clk) disable iff (rst)
        eoc |-> (dac_code == '0));

    // R5: the result moves only when eoc rises
    a_r5_result_on_eoc: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $rose(eoc));

    // R7: the filtered select takes a level only after it was held
    a_r7_select_held: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_n) |-> ($past(cs_n, 2) == sel_n && $past(cs_n, 3) == sel_n));

    // R8: after an accepted select change the sequencer is idle
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_n) |-> eoc);
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W), .FRAME(FRAME_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .dac_code(dac_code),
    .result  (result),
    .eoc     (eoc),
    .sel_n   (sel_n)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_tgl;
    logic       cs_n;
    logic [3:0] chan;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [9:0] result;
    logic       eoc;
    logic       sel_n;
    logic [9:0] stim;

    always #4 clk = ~clk;

    // ideal comparator against the stimulus code
    assign cmp_in = (dac_code <= stim);

    sar_conv_seq dut (
        .clk(clk), .rst(rst), .start_tgl(start_tgl), .cs_n(cs_n), .chan(chan),
        .cmp_in(cmp_in), .dac_code(dac_code), .result(result), .eoc(eoc), .sel_n(sel_n)
    );

    int         n_vec = 0;
    int         n_bad = 0;
    logic [9:0] exp_q[$];
    bit         abort_pend = 1'b0;
    logic [9:0] last_res = 10'h000;
    logic       eoc_d = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_conv(input logic [9:0] s, input logic [3:0] ch,
                              input bit expect_done, input logic [9:0] e);
        @(negedge clk);
        stim = s;
        chan = ch;
        start_tgl = ~start_tgl;
        if (expect_done) exp_q.push_back(e);
    endtask

    // monitor: pops the scoreboard at each rise of eoc
    always @(negedge clk) begin
        logic [9:0] e;
        if (!rst && eoc && !eoc_d) begin
            if (abort_pend) begin
                chk(result == last_res, "R8 result kept after abort", result, last_res);
                abort_pend = 1'b0;
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected completion", result, 0);
            end else begin
                e = exp_q.pop_front();
                chk(result == e, "R5 result equals input code", result, e);
                last_res = e;
            end
        end
        eoc_d = eoc;
    end

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] pats [8];
        int low_seen;
        pats = '{10'h000, 10'h3FF, 10'h1FF, 10'h200, 10'h155, 10'h2AA, 10'h001, 10'h3FE};
        rst = 1'b1; start_tgl = 1'b0; cs_n = 1'b1; chan = 4'h0; stim = 10'h000;
        wait_n(3);
        // R1 reset state
        chk(eoc == 1'b1, "R1 eoc", eoc, 1);
        chk(result == 10'h000, "R1 result", result, 0);
        chk(dac_code == 10'h000, "R1 dac_code", dac_code, 0);
        chk(sel_n == 1'b1, "R1 sel_n", sel_n, 1);
        rst = 1'b0;
        wait_n(2);

        // R2 / R3 / R4 timing of one conversion
        start_conv(10'h2C7, 4'h3, 1'b1, 10'h2C7);
        wait_n(2);
        chk(eoc == 1'b1, "R2 eoc still high", eoc, 1);
        wait_n(1);
        chk(eoc == 1'b0, "R2 eoc low on third edge", eoc, 0);
        wait_n(1);
        chk(dac_code == 10'h000, "R4 zero in setup", dac_code, 0);
        wait_n(1);
        chk(dac_code == 10'h200, "R4 first trial", dac_code, 10'h200);
        wait_n(3);
        chk(dac_code == 10'h200, "R4 first trial held", dac_code, 10'h200);
        wait_n(1);
        chk(dac_code == 10'h300, "R4 second trial", dac_code, 10'h300);
        wait_n(37);
        chk(eoc == 1'b0, "R3 eoc low at edge 46", eoc, 0);
        wait_n(1);
        chk(eoc == 1'b1, "R3 eoc high at edge 47", eoc, 1);
        wait_n(5);

        // R5 several codes
        foreach (pats[i]) begin
            start_conv(pats[i], 4'h1, 1'b1, pats[i]);
            wait_n(52);
        end
        for (int i = 0; i < 6; i++) begin
            logic [9:0] r;
            r = 10'($urandom);
            start_conv(r, 4'h7, 1'b1, r);
            wait_n(52);
        end

        // R9 test channels ignore the comparator
        start_conv(10'h155, 4'hB, 1'b1, 10'h200);
        wait_n(52);
        start_conv(10'h155, 4'hC, 1'b1, 10'h000);
        wait_n(52);
        start_conv(10'h155, 4'hD, 1'b1, 10'h3FF);
        wait_n(52);
        start_conv(10'h0F0, 4'hA, 1'b1, 10'h0F0);
        wait_n(52);

        // R6 second toggle during conversion is dropped
        start_conv(10'h123, 4'h2, 1'b1, 10'h123);
        wait_n(10);
        start_tgl = ~start_tgl;
        wait_n(45);
        low_seen = 0;
        for (int i = 0; i < 60; i++) begin
            wait_n(1);
            if (!eoc) low_seen++;
        end
        chk(low_seen == 0, "R6 no second conversion", low_seen, 0);

        // R7 glitch rejected, held level accepted on fourth edge
        cs_n = 1'b0;
        wait_n(1);
        cs_n = 1'b1;
        wait_n(6);
        chk(sel_n == 1'b1, "R7 glitch ignored", sel_n, 1);
        cs_n = 1'b0;
        wait_n(3);
        chk(sel_n == 1'b1, "R7 not yet accepted", sel_n, 1);
        wait_n(1);
        chk(sel_n == 1'b0, "R7 accepted on fourth edge", sel_n, 0);
        cs_n = 1'b1;
        wait_n(4);
        chk(sel_n == 1'b1, "R7 release accepted", sel_n, 1);
        wait_n(3);

        // R8 abort by asserting select
        abort_pend = 1'b1;
        start_conv(10'h0AB, 4'h5, 1'b0, 10'h000);
        wait_n(20);
        cs_n = 1'b0;
        wait_n(3);
        chk(eoc == 1'b0, "R8 still converting", eoc, 0);
        wait_n(1);
        chk(eoc == 1'b1, "R8 abort ends conversion", eoc, 1);
        wait_n(50);
        chk(result == 10'h123, "R8 no late result", result, 10'h123);
        chk(eoc == 1'b1, "R8 stays idle", eoc, 1);

        // R8 abort by releasing select
        abort_pend = 1'b1;
        start_conv(10'h3C3, 4'h6, 1'b0, 10'h000);
        wait_n(30);
        cs_n = 1'b1;
        wait_n(4);
        chk(eoc == 1'b1, "R8 release aborts", eoc, 1);
        wait_n(50);
        chk(result == 10'h123, "R8 result kept", result, 10'h123);

        // recovery after abort
        start_conv(10'h0AB, 4'h5, 1'b1, 10'h0AB);
        wait_n(52);

        chk(exp_q.size() == 0, "R5 every conversion reported", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule